// File: doc/BRIEF.md
# Host-to-Controller Doorbell Mailbox

This block is a memory-mapped mailbox between a host processor and a service controller. The host first loads up to sixteen bytes of parameters into a parameter buffer. It may also load a source pointer and a destination pointer. It then writes a command word. Accepting that word latches it for the controller, rings a one-cycle doorbell and marks the mailbox busy.

The controller reads the parameters through its own index/data port and may fill a sixteen-byte response buffer. It ends the exchange with a done strobe that carries an error flag and an eight-bit error code. If the accepted command asked for it, the host then receives a single-cycle completion pulse. Nothing has to be cleared afterwards.

The host polls a status word for the busy flag, the result and a sticky overrun flag. The overrun flag records a command write that arrived while an earlier command was still outstanding.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset, every host read returns the status word `{8'h00, 8'h00, INIT_ID, 8'h00}` at offset 0x04 and zero elsewhere. Every parameter word seen by the controller is zero, and `doorbell` and `irq_done` are low.
- R2: A full-word write (`h_wstrb` = 4'hF, `h_addr[1:0]` = 0) to offset 0x00 while the mailbox is idle has three effects. The word appears on `c_cmd` after that clock edge, `doorbell` is high for exactly the following cycle, and busy is set.
- R3: A full-word write to 0x00 while busy is dropped. `c_cmd` keeps its value, no doorbell follows and the overrun flag is set. The overrun flag stays set until the next accepted command write clears it.
- R4: The parameter buffer sits at 0x80, 0x84, 0x88 and 0x8C, one 32-bit word each. It takes full-word writes only: a write with any strobe bit low, or with `h_addr[1:0]` not zero, changes nothing. The controller reads word `c_pidx` on `c_pdata`, and the host reads zero there.
- R5: The controller writes response word `c_ridx` with `c_rwr`. With `h_rd_byte` = 0, the host reads the whole word at any address 0x90 to 0x9F, with `h_addr[3:2]` selecting the word and `h_addr[1:0]` ignored. With `h_rd_byte` = 1, the host reads byte lane `h_addr[1:0]` of that word (lane 0 = bits 7:0), zero-extended.
- R6: The status word at 0x04 holds the following fields: bit 0 busy, bit 1 error, bit 2 overrun and bit 3 zero; bits 7:4 hold bits 15:12 of the last accepted command; bits 15:8 hold INIT_ID; bits 23:16 hold the error code; bits 31:24 are zero.
- R7: `c_done` while busy clears busy and captures `c_err` and `c_ecode`, which then stay until the next completion. `c_done` while idle changes nothing.
- R8: `irq_done` is high for exactly the one cycle after a completion, and only when bit 8 of the completed command was set.
- R9: Full-word writes to 0x08 and 0x0C drive `c_src` and `c_dst`, and partial writes there are ignored. Host reads of 0x00, 0x08 and 0x0C return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_wstrb | input | 4 | Host byte strobes |
| h_addr | input | 8 | Host byte address for read and write |
| h_wdata | input | 32 | Host write data |
| h_rd_byte | input | 1 | Host read size: 1 = byte, 0 = word |
| h_rdata | output | 32 | Host read data, combinational from h_addr |
| doorbell | output | 1 | One-cycle pulse to the controller per accepted command |
| irq_done | output | 1 | One-cycle completion pulse to the host |
| c_cmd | output | 32 | Latched command word |
| c_src | output | 32 | Source pointer |
| c_dst | output | 32 | Destination pointer |
| c_pidx | input | 2 | Parameter buffer word index |
| c_pdata | output | 32 | Parameter buffer word |
| c_rwr | input | 1 | Response buffer write strobe |
| c_ridx | input | 2 | Response buffer word index |
| c_rwdata | input | 32 | Response buffer write data |
| c_done | input | 1 | Completion strobe |
| c_err | input | 1 | Error flag qualifying c_done |
| c_ecode | input | 8 | Error code qualifying c_done |

## Verification
The hardest state to reach is an overlap: a second command write landing while the first is still outstanding, followed by a completion that must finish only the first. The bench holds back `c_done`, issues the extra write during the busy window and then completes. It then checks three things: the latched command is unchanged, the completion pulse follows the first command's request bit, and the overrun flag survives until a fresh accepted command clears it. Partial-strobe and misaligned writes are also aimed at every writable location. The bench observes them through the controller's parameter read port and the pointer outputs.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int WORD_W = 32;
  localparam int CODE_W = 8;
  localparam int IOC_BIT = 8;

  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_SRC  = 8'h08;
  localparam logic [7:0] OFS_DST  = 8'h0C;
  localparam logic [7:0] OFS_WBUF = 8'h80;
  localparam logic [7:0] OFS_RBUF = 8'h90;

  typedef struct packed {
    logic [7:0]        zero_hi;
    logic [CODE_W-1:0] ecode;
    logic [7:0]        init_id;
    logic [3:0]        sub_id;
    logic              zero_b3;
    logic              ovr;
    logic              err;
    logic              busy;
  } stat_t;
endpackage

// File: rtl/mbox_buf.sv
module mbox_buf #(
  parameter int WORDS = 4,
  parameter int W     = 32,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] mem [WORDS];
  logic [WORDS-1:0] wen;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_comb wen[g] = we && (widx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem[g] <= '0;
      else if (wen[g]) mem[g] <= wdata;
    end
  end

  assign rdata = mem[ridx];

  // R4/R5: a written word reads back through this port one cycle later
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && ridx == widx) |=> (rdata == $past(wdata) || ridx != $past(widx) || we));
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_wdata,
  input  logic              done_i,
  input  logic              err_i,
  input  logic [CODE_W-1:0] ecode_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              ovr_o,
  output logic [CODE_W-1:0] ecode_o,
  output logic [WORD_W-1:0] cmd_o,
  output logic              doorbell_o,
  output logic              irq_o
);
  logic busy_q, busy_n, ovr_q, ovr_n, err_q, db_q, irq_q, irq_n;
  logic [CODE_W-1:0] ecode_q;
  logic [WORD_W-1:0] cmd_q;
  logic accept, finish;

  always_comb begin
    accept = cmd_wr && !busy_q;
    finish = done_i && busy_q;
    busy_n = busy_q;
    ovr_n  = ovr_q;
    if (cmd_wr && busy_q) ovr_n = 1'b1;
    if (accept) begin
      busy_n = 1'b1;
      ovr_n  = 1'b0;
    end
    if (finish) busy_n = 1'b0;
    irq_n = finish && cmd_q[IOC_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ovr_q  <= 1'b0;
      db_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      ovr_q  <= ovr_n;
      db_q   <= accept;
      irq_q  <= irq_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (accept) cmd_q <= cmd_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      ecode_q <= '0;
    end else if (finish) begin
      err_q   <= err_i;
      ecode_q <= ecode_i;
    end
  end

  assign busy_o     = busy_q;
  assign err_o      = err_q;
  assign ovr_o      = ovr_q;
  assign ecode_o    = ecode_q;
  assign cmd_o      = cmd_q;
  assign doorbell_o = db_q;
  assign irq_o      = irq_q;

  a_r2_busy_rings: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> db_q);
  a_r2_doorbell_busy: assert property (@(posedge clk) disable iff (!rst_n)
    db_q |-> busy_q);
  a_r3_drop_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy_q) |=> (!db_q && ovr_q && $stable(cmd_q)));
  a_r7_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && busy_q) |=> !busy_q);
  a_r7_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !busy_q && !cmd_wr) |=> ($stable(err_q) && $stable(ecode_q) && !irq_q));
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
  import mbox_pkg::*;
#(
  parameter int         BUF_WORDS = 4,
  parameter logic [7:0] INIT_ID   = 8'h5A,
  localparam int IDX_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1,
  localparam int AW    = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic [3:0]        h_wstrb,
  input  logic [7:0]        h_addr,
  input  logic [WORD_W-1:0] h_wdata,
  input  logic              h_rd_byte,
  output logic [WORD_W-1:0] h_rdata,
  output logic              doorbell,
  output logic              irq_done,
  output logic [WORD_W-1:0] c_cmd,
  output logic [WORD_W-1:0] c_src,
  output logic [WORD_W-1:0] c_dst,
  input  logic [IDX_W-1:0]  c_pidx,
  output logic [WORD_W-1:0] c_pdata,
  input  logic              c_rwr,
  input  logic [IDX_W-1:0]  c_ridx,
  input  logic [WORD_W-1:0] c_rwdata,
  input  logic              c_done,
  input  logic              c_err,
  input  logic [CODE_W-1:0] c_ecode
);
  logic full_wr, wr_cmd, wr_src, wr_dst, wr_wbuf, hit_rbuf;
  logic busy, err, ovr;
  logic [CODE_W-1:0] ecode;
  logic [WORD_W-1:0] src_q, dst_q, rb_word;
  logic [7:0] rb_byte;
  stat_t stat;

  always_comb begin
    full_wr  = h_wr && (h_wstrb == 4'hF) && (h_addr[1:0] == 2'b00);
    wr_cmd   = full_wr && (h_addr == OFS_CMD);
    wr_src   = full_wr && (h_addr == OFS_SRC);
    wr_dst   = full_wr && (h_addr == OFS_DST);
    wr_wbuf  = full_wr && (h_addr[7:AW] == OFS_WBUF[7:AW]);
    hit_rbuf = (h_addr[7:AW] == OFS_RBUF[7:AW]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= '0;
    else if (wr_src) src_q <= h_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dst_q <= '0;
    else if (wr_dst) dst_q <= h_wdata;
  end

  mbox_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(wr_cmd), .cmd_wdata(h_wdata),
    .done_i(c_done), .err_i(c_err), .ecode_i(c_ecode),
    .busy_o(busy), .err_o(err), .ovr_o(ovr), .ecode_o(ecode),
    .cmd_o(c_cmd), .doorbell_o(doorbell), .irq_o(irq_done)
  );

  mbox_buf #(.WORDS(BUF_WORDS), .W(WORD_W)) u_pbuf (
    .clk(clk), .rst_n(rst_n),
    .we(wr_wbuf), .widx(h_addr[AW-1:2]), .wdata(h_wdata),
    .ridx(c_pidx), .rdata(c_pdata)
  );

  mbox_buf #(.WORDS(BUF_WORDS), .W(WORD_W)) u_rbuf (
    .clk(clk), .rst_n(rst_n),
    .we(c_rwr), .widx(c_ridx), .wdata(c_rwdata),
    .ridx(h_addr[AW-1:2]), .rdata(rb_word)
  );

  always_comb begin
    stat.zero_hi = '0;
    stat.ecode   = ecode;
    stat.init_id = INIT_ID;
    stat.sub_id  = c_cmd[15:12];
    stat.zero_b3 = 1'b0;
    stat.ovr     = ovr;
    stat.err     = err;
    stat.busy    = busy;
    rb_byte = 8'(rb_word >> {h_addr[1:0], 3'b000});
    if (h_addr == OFS_STAT)  h_rdata = stat;
    else if (hit_rbuf)       h_rdata = h_rd_byte ? {24'h0, rb_byte} : rb_word;
    else                     h_rdata = '0;
  end

  assign c_src = src_q;
  assign c_dst = dst_q;

  a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_wr && h_addr == OFS_SRC) |=> $stable(c_src));
  a_r6_stat_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (h_addr == OFS_STAT) |-> (h_rdata[31:24] == 8'h00 && !h_rdata[3]));
endmodule

// File: tb/mbox_doorbell_tb.sv
module mbox_doorbell_tb;
  localparam logic [7:0] IID = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_wr = 0, h_rd_byte = 0, c_rwr = 0, c_done = 0, c_err = 0;
  logic [3:0] h_wstrb = 0;
  logic [7:0] h_addr = 0, c_ecode = 0;
  logic [31:0] h_wdata = 0, c_rwdata = 0;
  logic [1:0] c_pidx = 0, c_ridx = 0;
  logic [31:0] h_rdata, c_cmd, c_src, c_dst, c_pdata;
  logic doorbell, irq_done;

  int n_chk = 0, n_fail = 0;
  bit started = 0;

  mbox_doorbell #(.BUF_WORDS(4), .INIT_ID(IID)) u_dut (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_wstrb(h_wstrb), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rd_byte(h_rd_byte), .h_rdata(h_rdata),
    .doorbell(doorbell), .irq_done(irq_done), .c_cmd(c_cmd), .c_src(c_src),
    .c_dst(c_dst), .c_pidx(c_pidx), .c_pdata(c_pdata), .c_rwr(c_rwr),
    .c_ridx(c_ridx), .c_rwdata(c_rwdata), .c_done(c_done), .c_err(c_err),
    .c_ecode(c_ecode));

  always #10 clk = ~clk;

  // behavioural reference model
  logic m_busy, m_err, m_ovr, m_db, m_irq;
  logic [7:0] m_ecode;
  logic [31:0] m_cmd, m_src, m_dst;
  logic [31:0] m_wbuf [4];
  logic [31:0] m_rbuf [4];
  bit full, acc, fin;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_err = 0; m_ovr = 0; m_db = 0; m_irq = 0; m_ecode = 0;
      m_cmd = 0; m_src = 0; m_dst = 0;
      for (int i = 0; i < 4; i++) begin m_wbuf[i] = 0; m_rbuf[i] = 0; end
    end else begin
      full = h_wr && h_wstrb == 4'hF && h_addr[1:0] == 2'b00;
      acc  = full && h_addr == 8'h00 && !m_busy;
      fin  = c_done && m_busy;
      m_db  = acc;
      m_irq = fin && m_cmd[8];
      if (full && h_addr == 8'h00 && m_busy) m_ovr = 1;
      if (acc) begin m_cmd = h_wdata; m_busy = 1; m_ovr = 0; end
      if (fin) begin m_busy = 0; m_err = c_err; m_ecode = c_ecode; end
      if (full && h_addr == 8'h08) m_src = h_wdata;
      if (full && h_addr == 8'h0C) m_dst = h_wdata;
      if (full && h_addr[7:4] == 4'h8) m_wbuf[h_addr[3:2]] = h_wdata;
      if (c_rwr) m_rbuf[c_ridx] = c_rwdata;
    end
  end

  function automatic logic [31:0] model_rd();
    logic [31:0] w;
    if (h_addr == 8'h04)
      return {8'h00, m_ecode, IID, m_cmd[15:12], 1'b0, m_ovr, m_err, m_busy};
    if (h_addr[7:4] == 4'h9) begin
      w = m_rbuf[h_addr[3:2]];
      return h_rd_byte ? ((w >> (8 * h_addr[1:0])) & 32'hFF) : w;
    end
    return 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (started && rst_n) begin
      check("R2 doorbell", {31'b0, doorbell}, {31'b0, m_db});
      check("R8 irq_done", {31'b0, irq_done}, {31'b0, m_irq});
      check("R2 c_cmd", c_cmd, m_cmd);
      check("R9 c_src", c_src, m_src);
      check("R9 c_dst", c_dst, m_dst);
      check("R4 c_pdata", c_pdata, m_wbuf[c_pidx]);
      check("R6 h_rdata", h_rdata, model_rd());
    end
  end

  task automatic step(); @(posedge clk); #2; endtask

  task automatic hw(logic [7:0] a, logic [31:0] d, logic [3:0] s);
    h_addr = a; h_wdata = d; h_wstrb = s; h_wr = 1; step(); h_wr = 0;
  endtask

  task automatic hrd(string tag, logic [7:0] a, logic byte_rd, logic [31:0] exp);
    h_addr = a; h_rd_byte = byte_rd; @(negedge clk); check(tag, h_rdata, exp); step();
  endtask

  task automatic done(logic e, logic [7:0] code);
    c_done = 1; c_err = e; c_ecode = code; step(); c_done = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1; started = 1;
    step();
    // R1 reset state
    hrd("R1 status", 8'h04, 0, {16'h0, IID, 8'h00});
    hrd("R1 rbuf", 8'h94, 0, 32'h0);
    c_pidx = 2'd3; @(negedge clk); check("R1 pbuf", c_pdata, 32'h0);
    check("R1 doorbell", {31'b0, doorbell}, 32'h0);
    step();
    // R4 parameter buffer
    for (int i = 0; i < 4; i++) hw(8'h80 + 8'(4 * i), 32'hA000_0000 + i, 4'hF);
    hw(8'h84, 32'hDEAD_BEEF, 4'h7);
    hw(8'h89, 32'hDEAD_BEEF, 4'hF);
    c_pidx = 2'd1; @(negedge clk); check("R4 partial ignored", c_pdata, 32'hA000_0001);
    c_pidx = 2'd2; @(negedge clk); check("R4 misaligned ignored", c_pdata, 32'hA000_0002);
    hrd("R4 host reads zero", 8'h80, 0, 32'h0);
    // R9 pointers
    hw(8'h08, 32'h1234_5678, 4'hF);
    hw(8'h0C, 32'h9ABC_DEF0, 4'hF);
    hw(8'h0C, 32'h0, 4'h1);
    @(negedge clk); check("R9 src", c_src, 32'h1234_5678);
    check("R9 dst", c_dst, 32'h9ABC_DEF0);
    hrd("R9 read 08 zero", 8'h08, 0, 32'h0);
    // R2 command with completion request, sub 3, size 8
    hw(8'h00, 32'h0008_31A5, 4'hF);
    @(negedge clk); check("R2 doorbell pulse", {31'b0, doorbell}, 32'h1);
    check("R2 cmd latched", c_cmd, 32'h0008_31A5);
    step();
    hrd("R6 status busy", 8'h04, 0, {16'h0, IID, 8'h31});
    // R3 overlapping command dropped
    hw(8'h00, 32'h0000_20FF, 4'hF);
    @(negedge clk); check("R3 no doorbell", {31'b0, doorbell}, 32'h0);
    check("R3 cmd kept", c_cmd, 32'h0008_31A5);
    step();
    hrd("R3 overrun set", 8'h04, 0, {16'h0, IID, 8'h35});
    // R5 response buffer
    c_rwr = 1; c_ridx = 0; c_rwdata = 32'h4433_2211; step();
    c_ridx = 3; c_rwdata = 32'hCAFE_F00D; step(); c_rwr = 0;
    hrd("R5 word", 8'h90, 0, 32'h4433_2211);
    hrd("R5 byte lane2", 8'h92, 1, 32'h33);
    hrd("R5 byte lane3 word3", 8'h9F, 1, 32'hCA);
    hrd("R5 word ignores low bits", 8'h9D, 0, 32'hCAFE_F00D);
    // R7/R8 completion with error
    done(1, 8'h42);
    @(negedge clk); check("R8 irq pulse", {31'b0, irq_done}, 32'h1);
    step();
    @(negedge clk); check("R8 irq single", {31'b0, irq_done}, 32'h0);
    hrd("R7 status done err", 8'h04, 0, {8'h0, 8'h42, IID, 8'h36});
    // R7 done while idle ignored
    done(0, 8'h77);
    hrd("R7 idle done ignored", 8'h04, 0, {8'h0, 8'h42, IID, 8'h36});
    // second command without completion request clears overrun
    hw(8'h00, 32'h0004_7010, 4'hF);
    step();
    hrd("R3 overrun cleared", 8'h04, 0, {8'h0, 8'h42, IID, 8'h73});
    done(0, 8'h00);
    @(negedge clk); check("R8 no irq without request", {31'b0, irq_done}, 32'h0);
    step();
    hrd("R7 status clean", 8'h04, 0, {16'h0, IID, 8'h70});
    hrd("R9 read 00 zero", 8'h00, 0, 32'h0);
    repeat (3) step();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule